// File: doc/BRIEF.md
# Serial Front-End Link Decoder

This block turns one serial data link from a detector front end, sampled once per system clock, into 32-bit words for a link FIFO. Each word leaves with a one-cycle write strobe and a 2-bit type tag. In normal data taking the decoder waits for a rising edge on the line. It reads a 6-bit header field that begins with that edge, then an 8-bit event identifier, and writes a header word. After that it packs each 24-bit hit record into a hit word, and writes a trailer word once the line has stayed low for 22 bit times.

If the header field is malformed, the link is out of sync. The decoder then stores a single raw word and goes silent until it sees a trailer, so one broken event cannot flood the readout. For link debugging, a configuration input puts the decoder into free-running raw capture. Capture begins with the first rising edge, and that edge is the first captured bit.

A short register chain conditions the input before any decoding. A per-link enable can silence an input that is stuck high. A half-clock mask accepts the header pattern that front ends running at half rate produce. A programmable bit budget stops any packet that never closes.

Top module: `lnk_decoder`

## Requirements
- R1: After a rising edge the decoder reads a 6-bit header field, MSB first, starting with that edge bit. If the field is 111010, the next 8 bits are the event identifier. It then writes one word with type 00 and data {24'b0, identifier}.
- R2: After the header, a 1 bit starts a 24-bit hit record whose first bit is that 1. The record produces one word with type 01 and data {8'b0, record}, MSB first. Any number of 0 bits may fall between records.
- R3: After the header, 22 consecutive 0 bits close the packet with one word of type 10 and data {24'b0, identifier}. A packet with no hits therefore gives a header word and a trailer word and nothing else.
- R4: Any other header field is a sync error. It gives exactly one word of type 11 whose data are the 32 consecutive input bits starting with the edge bit, MSB first. Nothing more is written until 22 consecutive 0 bits have been seen, and normal decoding resumes after that.
- R5: The field 111101 is a sync error while half_clk_mask is 0. While half_clk_mask is 1 it is accepted as a valid header.
- R6: If raw_force is 1 when a rising edge arrives at an idle decoder, every following block of 32 bits, starting with that edge bit, is written as a type-11 word. This continues until raw_force is seen low. The bit that sees it low and any partial word are dropped.
- R7: A packet starts only on a 0-to-1 transition of the conditioned input. A line held at 1 does not start new packets.
- R8: While link_en is 0 the input is treated as constant 0, so no word and no timeout is produced.
- R9: If a packet has used timeout_limit bits (counting the edge bit) without completing, the next bit is discarded. The decoder returns to idle, writes no word and pulses timeout_o for one cycle.
- R10: During and right after a synchronous reset, wr_o and timeout_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one link bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| link_in | input | 1 | Serial data from the front end |
| link_en | input | 1 | Link enable; 0 forces the input to 0 |
| raw_force | input | 1 | Free-running raw capture request |
| half_clk_mask | input | 1 | Accept the half-rate header pattern |
| timeout_limit | input | TO_W | Bit budget per packet |
| wr_o | output | 1 | Word write strobe |
| wtype_o | output | 2 | Word type: 00 header, 01 hit, 10 trailer, 11 raw |
| wdata_o | output | WORD_W | Word data |
| timeout_o | output | 1 | One-cycle pulse on a budget expiry |

## Verification
The hardest case to reach from the ports is the silent wait after a sync error. There, a raw word has already been written, and hit-like 1 bits must be swallowed until a full trailer-length gap appears. Random bit tails after corrupted header fields keep the decoder in that wait while ones keep resetting its zero run. A line held high exercises the same path and also shows that a steady 1 starts no new packet. The budget expiry is reached by shrinking timeout_limit below the length of a three-hit packet, so the abort lands inside a hit record.

// File: rtl/lnk_dec_pkg.sv
package lnk_dec_pkg;
  localparam int FIELD_W = 6;
  localparam logic [FIELD_W-1:0] HDR_PAT  = 6'b111010;
  localparam logic [FIELD_W-1:0] HALF_PAT = 6'b111101;

  typedef enum logic [1:0] {
    WT_HDR = 2'b00,
    WT_HIT = 2'b01,
    WT_TRL = 2'b10,
    WT_RAW = 2'b11
  } wtype_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_EVID, S_DATA, S_HIT, S_RAW1, S_WAIT, S_RAWF
  } dec_state_e;
endpackage

// File: rtl/lnk_precond.sv
module lnk_precond #(
  parameter int PRE_STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic link_i,
  input  logic en_i,
  output logic bit_o
);
  logic [PRE_STAGES-1:0] pre_q;
  logic                  en_q;
  logic                  bit_q;

  generate
    if (PRE_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= link_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= {pre_q[PRE_STAGES-2:0], link_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      en_q  <= en_i;
      bit_q <= pre_q[PRE_STAGES-1] & en_q;
    end
  end

  assign bit_o = bit_q;

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !bit_q);
endmodule

// File: rtl/lnk_pkt_timer.sv
module lnk_pkt_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            busy_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expired_o
);
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (start_i)               cnt_q <= TO_W'(1);
    else if (!busy_i)               cnt_q <= '0;
    else if (!expired_o)            cnt_q <= cnt_q + TO_W'(1);
  end

  assign expired_o = busy_i && (cnt_q == limit_i);

  // R9
  budget_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_i && limit_i != '0 && $stable(limit_i)) |-> (cnt_q <= limit_i));
endmodule

// File: rtl/lnk_frame_fsm.sv
module lnk_frame_fsm
  import lnk_dec_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ID_W      = 8,
  parameter int HIT_W     = 24,
  parameter int TRL_ZEROS = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_i,
  input  logic              raw_force_i,
  input  logic              half_mask_i,
  input  logic              expired_i,
  output logic              start_o,
  output logic              busy_o,
  output logic              wr_o,
  output logic [1:0]        wtype_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              timeout_o
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam int ZW = $clog2(TRL_ZEROS + 1);

  dec_state_e        st_q;
  logic [WORD_W-1:0] sh_q, sh_nx;
  logic [CW-1:0]     cnt_q;
  logic [ZW-1:0]     zc_q;
  logic [ID_W-1:0]   id_q;
  logic              prev_q, rise;
  logic              wr_q, to_q;
  wtype_e            wt_q;
  logic [WORD_W-1:0] wd_q;
  logic              field_ok;

  assign sh_nx    = {sh_q[WORD_W-2:0], bit_i};
  assign rise     = bit_i & ~prev_q;
  assign busy_o   = st_q inside {S_HDR, S_EVID, S_DATA, S_HIT, S_RAW1, S_WAIT};
  assign start_o  = (st_q == S_IDLE) && rise && !raw_force_i;
  assign field_ok = (sh_nx[FIELD_W-1:0] == HDR_PAT) ||
                    (half_mask_i && sh_nx[FIELD_W-1:0] == HALF_PAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      zc_q   <= '0;
      id_q   <= '0;
      prev_q <= 1'b0;
      wr_q   <= 1'b0;
      to_q   <= 1'b0;
      wt_q   <= WT_HDR;
      wd_q   <= '0;
    end else begin
      prev_q <= bit_i;
      wr_q   <= 1'b0;
      to_q   <= 1'b0;
      sh_q   <= sh_nx;
      cnt_q  <= cnt_q + CW'(1);
      if (busy_o && expired_i) begin
        st_q <= S_IDLE;
        to_q <= 1'b1;
      end else begin
        case (st_q)
          S_IDLE: if (rise) begin
            sh_q  <= {{(WORD_W-1){1'b0}}, 1'b1};
            cnt_q <= CW'(1);
            st_q  <= raw_force_i ? S_RAWF : S_HDR;
          end
          S_HDR: if (cnt_q == CW'(FIELD_W-1)) begin
            if (field_ok) begin
              st_q  <= S_EVID;
              cnt_q <= '0;
            end else begin
              st_q  <= S_RAW1;
            end
          end
          S_EVID: if (cnt_q == CW'(ID_W-1)) begin
            id_q <= sh_nx[ID_W-1:0];
            wr_q <= 1'b1;
            wt_q <= WT_HDR;
            wd_q <= {{(WORD_W-ID_W){1'b0}}, sh_nx[ID_W-1:0]};
            st_q <= S_DATA;
            zc_q <= '0;
          end
          S_DATA: begin
            if (bit_i) begin
              st_q  <= S_HIT;
              cnt_q <= CW'(1);
            end else if (zc_q == ZW'(TRL_ZEROS-1)) begin
              wr_q <= 1'b1;
              wt_q <= WT_TRL;
              wd_q <= {{(WORD_W-ID_W){1'b0}}, id_q};
              st_q <= S_IDLE;
            end else begin
              zc_q <= zc_q + ZW'(1);
            end
          end
          S_HIT: if (cnt_q == CW'(HIT_W-1)) begin
            wr_q <= 1'b1;
            wt_q <= WT_HIT;
            wd_q <= {{(WORD_W-HIT_W){1'b0}}, sh_nx[HIT_W-1:0]};
            st_q <= S_DATA;
            zc_q <= '0;
          end
          S_RAW1: if (cnt_q == CW'(WORD_W-1)) begin
            wr_q <= 1'b1;
            wt_q <= WT_RAW;
            wd_q <= sh_nx;
            st_q <= S_WAIT;
            zc_q <= '0;
          end
          S_WAIT: begin
            if (bit_i)                             zc_q <= '0;
            else if (zc_q == ZW'(TRL_ZEROS-1))     st_q <= S_IDLE;
            else                                   zc_q <= zc_q + ZW'(1);
          end
          S_RAWF: begin
            if (!raw_force_i) begin
              st_q <= S_IDLE;
            end else if (cnt_q == CW'(WORD_W-1)) begin
              wr_q  <= 1'b1;
              wt_q  <= WT_RAW;
              wd_q  <= sh_nx;
              cnt_q <= '0;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign wr_o      = wr_q;
  assign wtype_o   = wt_q;
  assign wdata_o   = wd_q;
  assign timeout_o = to_q;

  // R4
  wait_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_WAIT) |=> !wr_q);
  // R3
  trailer_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_q && wt_q == WT_TRL) |-> (st_q == S_IDLE));
  // R2
  hit_resumes_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_q && wt_q == WT_HIT) |-> (st_q == S_DATA));
  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    to_q |-> (!wr_q && st_q == S_IDLE));
endmodule

// File: rtl/lnk_decoder.sv
module lnk_decoder #(
  parameter int WORD_W     = 32,
  parameter int ID_W       = 8,
  parameter int HIT_W      = 24,
  parameter int TRL_ZEROS  = 22,
  parameter int PRE_STAGES = 3,
  parameter int TO_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_in,
  input  logic              link_en,
  input  logic              raw_force,
  input  logic              half_clk_mask,
  input  logic [TO_W-1:0]   timeout_limit,
  output logic              wr_o,
  output logic [1:0]        wtype_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              timeout_o
);
  logic bit_c, start_c, busy_c, expired_c;

  lnk_precond #(.PRE_STAGES(PRE_STAGES)) u_pre (
    .clk(clk), .rst(rst), .link_i(link_in), .en_i(link_en), .bit_o(bit_c)
  );

  lnk_pkt_timer #(.TO_W(TO_W)) u_tmr (
    .clk(clk), .rst(rst), .start_i(start_c), .busy_i(busy_c),
    .limit_i(timeout_limit), .expired_o(expired_c)
  );

  lnk_frame_fsm #(
    .WORD_W(WORD_W), .ID_W(ID_W), .HIT_W(HIT_W), .TRL_ZEROS(TRL_ZEROS)
  ) u_fsm (
    .clk(clk), .rst(rst), .bit_i(bit_c), .raw_force_i(raw_force),
    .half_mask_i(half_clk_mask), .expired_i(expired_c),
    .start_o(start_c), .busy_o(busy_c), .wr_o(wr_o), .wtype_o(wtype_o),
    .wdata_o(wdata_o), .timeout_o(timeout_o)
  );
endmodule

// File: tb/lnk_decoder_tb_top.sv
module lnk_decoder_tb_top;
  localparam int LAT = 4;  // conditioning stages + output register of the chain

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_in = 1'b0, link_en = 1'b0, raw_force = 1'b0, half_clk_mask = 1'b0;
  logic [15:0] timeout_limit = 16'd4000;
  logic wr_o, timeout_o;
  logic [1:0] wtype_o;
  logic [31:0] wdata_o;

  always #2 clk = ~clk;

  lnk_decoder dut_i (
    .clk(clk), .rst(rst), .link_in(link_in), .link_en(link_en),
    .raw_force(raw_force), .half_clk_mask(half_clk_mask),
    .timeout_limit(timeout_limit), .wr_o(wr_o), .wtype_o(wtype_o),
    .wdata_o(wdata_o), .timeout_o(timeout_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [34:0] got_q[$], exp_q[$];
  logic nxt_en = 1'b0, nxt_raw = 1'b0, nxt_half = 1'b0;
  int   nxt_lim = 4000;
  logic hist [LAT];

  // reference state
  int m_st = 0, m_cnt = 0, m_zc = 0, m_to = 0;
  logic [31:0] m_sh = '0;
  logic [7:0]  m_id = '0;
  logic        m_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [34:0] act, input logic [34:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push_exp(input logic [2:0] tag, input logic [31:0] d);
    exp_q.push_back({tag, d});
  endtask

  task automatic model_step(input logic b, input logic rf, input logic hm, input int lim);
    logic [31:0] nx;
    bit rise;
    nx = {m_sh[30:0], b};
    rise = b && !m_prev;
    m_prev = b;
    m_sh = nx;
    if (m_st >= 1 && m_st <= 6 && m_to == lim) begin  // R9 budget spent
      push_exp(3'd4, 32'd0);
      m_st = 0;
      return;
    end
    if (m_st >= 1 && m_st <= 6) m_to++;
    case (m_st)
      0: if (rise) begin m_sh = 32'd1; m_cnt = 1; m_to = 1; m_st = rf ? 7 : 1; end
      1: begin
        m_cnt++;
        if (m_cnt == 6) begin
          if (nx[5:0] == 6'b111010 || (hm && nx[5:0] == 6'b111101)) begin m_st = 2; m_cnt = 0; end
          else m_st = 5;
        end
      end
      2: begin
        m_cnt++;
        if (m_cnt == 8) begin m_id = nx[7:0]; push_exp(3'd0, {24'd0, nx[7:0]}); m_st = 3; m_zc = 0; end
      end
      3: if (b) begin m_st = 4; m_cnt = 1; end
         else begin m_zc++; if (m_zc == 22) begin push_exp(3'd2, {24'd0, m_id}); m_st = 0; end end
      4: begin
        m_cnt++;
        if (m_cnt == 24) begin push_exp(3'd1, {8'd0, nx[23:0]}); m_st = 3; m_zc = 0; end
      end
      5: begin
        m_cnt++;
        if (m_cnt == 32) begin push_exp(3'd3, nx); m_st = 6; m_zc = 0; end
      end
      6: if (b) m_zc = 0;
         else begin m_zc++; if (m_zc == 22) m_st = 0; end
      7: if (!rf) m_st = 0;
         else begin m_cnt++; if (m_cnt == 32) begin push_exp(3'd3, nx); m_cnt = 0; end end
      default: m_st = 0;
    endcase
  endtask

  task automatic send(input logic b);
    logic old;
    @(negedge clk);
    link_in = b; link_en = nxt_en; raw_force = nxt_raw;
    half_clk_mask = nxt_half; timeout_limit = 16'(nxt_lim);
    old = hist[LAT-1];
    for (int i = LAT-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = b & nxt_en;
    model_step(old, nxt_raw, nxt_half, nxt_lim);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n-1; i >= 0; i--) send(v[i]);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) send(1'b0);
  endtask

  task automatic packet(input logic [5:0] field, input logic [7:0] id, input int nh);
    send_bits({26'd0, field}, 6);
    send_bits({24'd0, id}, 8);
    for (int h = 0; h < nh; h++) begin
      zeros($urandom % 5);
      send_bits({8'd0, 1'b1, 23'($urandom)}, 24);
    end
    zeros(24 + $urandom % 4);
  endtask

  task automatic bad_packet(input logic [5:0] field);
    send_bits({26'd0, field}, 6);
    for (int i = 0; i < 40; i++) send(1'($urandom));
    zeros(30);
  endtask

  task automatic compare(input string req);
    zeros(10);
    chk(got_q.size() == exp_q.size(), {req, " word count"},
        35'(got_q.size()), 35'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] === exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_o)      got_q.push_back({1'b0, wtype_o, wdata_o});
      if (timeout_o) got_q.push_back({3'd4, 32'd0});
    end
  end

  initial begin
    for (int i = 0; i < LAT; i++) hist[i] = 1'b0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(wr_o === 1'b0, "R10 wr_o in reset", 35'(wr_o), 35'd0);
    chk(timeout_o === 1'b0, "R10 timeout_o in reset", 35'(timeout_o), 35'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_o === 1'b0 && timeout_o === 1'b0, "R10 after reset", 35'({wr_o, timeout_o}), 35'd0);

    // R8 disabled link: a full valid packet produces nothing
    zeros(5);
    packet(6'b111010, 8'h5A, 2);
    compare("R8");

    nxt_en = 1'b1;
    zeros(12);
    // R3 empty packet: header then trailer only
    packet(6'b111010, 8'hC3, 0);
    compare("R3");
    // R1 R2 header with hits
    packet(6'b111010, 8'h17, 3);
    compare("R1/R2");
    // R4 sync error: one raw word then silence until trailer gap
    bad_packet(6'b110110);
    packet(6'b111010, 8'h81, 1);
    compare("R4");
    // R5 half-clock pattern rejected then accepted
    bad_packet(6'b111101);
    nxt_half = 1'b1;
    packet(6'b111101, 8'h3E, 1);
    nxt_half = 1'b0;
    zeros(4);
    compare("R5");
    // R7 line held high: only one raw word
    for (int i = 0; i < 80; i++) send(1'b1);
    zeros(30);
    compare("R7");
    // R9 budget smaller than a three-hit packet
    nxt_lim = 60;
    zeros(2);
    send_bits({26'd0, 6'b111010}, 6);
    send_bits(32'hA5, 8);
    for (int h = 0; h < 3; h++) send_bits({8'd0, 24'hF0F0F1}, 24);
    zeros(30);
    nxt_lim = 4000;
    zeros(2);
    compare("R9");
    // R6 forced raw capture from first edge, partial word dropped
    nxt_raw = 1'b1;
    zeros(8);
    send(1'b1);
    for (int i = 0; i < 75; i++) send(1'($urandom));
    zeros(6);
    nxt_raw = 1'b0;
    zeros(40);
    compare("R6");

    // random mix
    for (int p = 0; p < 24; p++) begin
      logic [5:0] f;
      nxt_half = 1'($urandom);
      zeros(3 + $urandom % 6);
      if ($urandom % 5 == 0) begin
        f = {1'b1, 5'($urandom)};
        if (f == 6'b111010 || f == 6'b111101) f = 6'b100110;
        bad_packet(f);
      end else begin
        f = (nxt_half && ($urandom % 2 == 1)) ? 6'b111101 : 6'b111010;
        packet(f, 8'($urandom), $urandom % 4);
      end
    end
    nxt_half = 1'b0;
    compare("R1/R2/R3/R4/R5 random");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule